// File: doc/BRIEF.md
# Soft-Ramp Output Power Sequencer

This block sequences the digital output level of an audio converter path through power-up and power-down. After reset it holds the path in power-down, with the output level clamped at zero. It watches two status flags that a separate clock-detection block supplies: one says the system clock is running, and the other says the frame clock is valid. Clock detection itself is not part of this block.

Once both flags are high, the sequencer raises an internal 10-bit level from zero to mid-scale (512), which is the common-mode point of the output. The level moves by one code per frame period. When the ramp completes, audio samples pass straight to the output. If the frame clock is lost while the system clock still runs, the level steps back down to zero before power-down is re-entered. If the system clock itself is lost, the block drops at once to power-down.

The frame pacing comes from a step timer that counts `STEP_CYCLES` cycles of the block clock. Because of this, a ramp-down still paces correctly after the frame clock has stopped.

Top module: `softRampCtl`

## Requirements
- R1: After reset is released, `stateOut` reads 0 (power-down), `levelOut` reads 0 and `clampOut` is 1.
- R2: In power-down the block stays in power-down, with `levelOut` at 0, for as long as `sysClkOk` or `frameClkOk` is low.
- R3: In power-down with both `sysClkOk` and `frameClkOk` high, the clock edge that samples them moves `stateOut` to 1 (ramp-up), with `levelOut` still 0.
- R4: In ramp-up, `levelOut` rises by exactly one code each `STEP_CYCLES` clock cycles. The first step lands `STEP_CYCLES` edges after ramp-up is entered, and the level never changes in any other cycle.
- R5: When the ramp-up level has reached mid-scale, 512 (1 << (LVL_W-1)), the next edge moves `stateOut` to 2 (normal). In normal, `levelOut` equals `sampleIn`.
- R6: In every state other than normal, `levelOut` is the ramp level and `sampleIn` has no effect on it.
- R7: With `sysClkOk` high, losing `frameClkOk` in ramp-up or normal moves `stateOut` to 3 (ramp-down) at the next edge. In ramp-down the level falls by one code each `STEP_CYCLES` cycles, and one edge after it reaches 0 the state returns to 0.
- R8: When `sysClkOk` is low in any state other than power-down, the next edge sets `stateOut` to 0, `levelOut` to 0 and `clampOut` to 1.
- R9: The state codes are 0 power-down, 1 ramp-up, 2 normal and 3 ramp-down. `clampOut` is 1 exactly when `stateOut` is 0.
- R10: A ramp-down is not cut short if `frameClkOk` returns. It runs to zero and enters power-down, and the next edge starts a fresh ramp-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock; the step timer counts it |
| rstN | input | 1 | Active-low synchronous reset |
| sysClkOk | input | 1 | System clock reported present |
| frameClkOk | input | 1 | Frame clock reported present and valid |
| sampleIn | input | LVL_W | Audio sample, passed through in normal |
| levelOut | output | LVL_W | Ramp level or audio sample |
| clampOut | output | 1 | High while the output is clamped in power-down |
| stateOut | output | 2 | Sequencer state code |

## Verification
Every cycle, the assertions check the single-step shape of both ramps, the wake-up and hold rules in power-down, the immediate fall to power-down when the system clock goes, audio pass-through in normal, and the tie between clamp and state. Only the directed scenarios can show the exact pacing: the first step landing `STEP_CYCLES` edges after ramp-up begins, the full 512-step climb ending in normal, and a complete ramp-down that goes on after the frame clock returns and then re-arms.

// File: rtl/softramp_pkg.sv
package softramp_pkg;

  typedef enum logic [1:0] {
    ST_POWER_DOWN = 2'd0,
    ST_RAMP_UP    = 2'd1,
    ST_NORMAL     = 2'd2,
    ST_RAMP_DOWN  = 2'd3
  } rampState_e;

  // Strobes from the sequencer to the level datapath
  typedef struct packed {
    logic clearLevel;
    logic stepUp;
    logic stepDown;
    logic timerRun;
    logic passAudio;
  } rampCmd_t;

endpackage

// File: rtl/rampControl.sv
module rampControl
  import softramp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysClkOk,
  input  logic       frameClkOk,
  input  logic       atMid,
  input  logic       atZero,
  output rampCmd_t   cmd,
  output rampState_e state
);

  rampState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_POWER_DOWN: begin
        if (sysClkOk && frameClkOk) nextState = ST_RAMP_UP;
      end
      ST_RAMP_UP: begin
        if (!sysClkOk)        nextState = ST_POWER_DOWN;
        else if (!frameClkOk) nextState = ST_RAMP_DOWN;
        else if (atMid)       nextState = ST_NORMAL;
      end
      ST_NORMAL: begin
        if (!sysClkOk)        nextState = ST_POWER_DOWN;
        else if (!frameClkOk) nextState = ST_RAMP_DOWN;
      end
      ST_RAMP_DOWN: begin
        if (!sysClkOk || atZero) nextState = ST_POWER_DOWN;
      end
      default: nextState = ST_POWER_DOWN;
    endcase
  end

  always_comb begin
    cmd            = '0;
    cmd.clearLevel = (nextState == ST_POWER_DOWN);
    cmd.stepUp     = (state == ST_RAMP_UP);
    cmd.stepDown   = (state == ST_RAMP_DOWN);
    cmd.timerRun   = (state == ST_RAMP_UP) || (state == ST_RAMP_DOWN);
    cmd.passAudio  = (state == ST_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_POWER_DOWN;
    else       state <= nextState;
  end

endmodule

// File: rtl/rampDatapath.sv
module rampDatapath
  import softramp_pkg::*;
#(
  parameter int LVL_W       = 10,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rampCmd_t         cmd,
  input  logic [LVL_W-1:0] sampleIn,
  output logic [LVL_W-1:0] levelOut,
  output logic             atMid,
  output logic             atZero
);

  localparam int TMR_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYCLES - 1);
  localparam logic [LVL_W-1:0] MID_LEVEL = LVL_W'(1) << (LVL_W - 1);

  logic [TMR_W-1:0] stepCnt;
  logic             stepDue;
  logic [LVL_W-1:0] level;

  // Frame-rate step timer
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.timerRun) stepCnt <= '0;
    else if (stepCnt == TMR_LAST) stepCnt <= '0;
    else                          stepCnt <= stepCnt + 1'b1;
  end

  assign stepDue = cmd.timerRun && (stepCnt == TMR_LAST);
  assign atMid   = (level == MID_LEVEL);
  assign atZero  = (level == '0);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clearLevel)                level <= '0;
    else if (stepDue && cmd.stepUp && !atMid)   level <= level + 1'b1;
    else if (stepDue && cmd.stepDown && !atZero) level <= level - 1'b1;
  end

  assign levelOut = cmd.passAudio ? sampleIn : level;

endmodule

// File: rtl/softRampCtl.sv
module softRampCtl
  import softramp_pkg::*;
#(
  parameter int LVL_W       = 10,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sysClkOk,
  input  logic             frameClkOk,
  input  logic [LVL_W-1:0] sampleIn,
  output logic [LVL_W-1:0] levelOut,
  output logic             clampOut,
  output logic [1:0]       stateOut
);

  rampCmd_t   cmd;
  rampState_e state;
  logic       atMid;
  logic       atZero;

  rampControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sysClkOk   (sysClkOk),
    .frameClkOk (frameClkOk),
    .atMid      (atMid),
    .atZero     (atZero),
    .cmd        (cmd),
    .state      (state)
  );

  rampDatapath #(
    .LVL_W       (LVL_W),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sampleIn (sampleIn),
    .levelOut (levelOut),
    .atMid    (atMid),
    .atZero   (atZero)
  );

  assign stateOut = state;
  assign clampOut = (state == ST_POWER_DOWN);

endmodule

// File: rtl/softRampChk.sv
module softRampChk #(
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             sysClkOk,
  input logic             frameClkOk,
  input logic [LVL_W-1:0] sampleIn,
  input logic [LVL_W-1:0] levelOut,
  input logic             clampOut,
  input logic [1:0]       stateOut
);

  localparam logic [LVL_W-1:0] MID = LVL_W'(1) << (LVL_W - 1);

  p_hold_pd_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd0 && !(sysClkOk && frameClkOk)) |=> (stateOut == 2'd0 && levelOut == '0));

  p_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd0 && sysClkOk && frameClkOk) |=> (stateOut == 2'd1 && levelOut == '0));

  p_up_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd1 && sysClkOk && frameClkOk && levelOut != MID) |=>
      (stateOut == 2'd1 && (levelOut == $past(levelOut) || levelOut == $past(levelOut) + 1'b1)));

  p_to_normal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd1 && sysClkOk && frameClkOk && levelOut == MID) |=> (stateOut == 2'd2));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd2) |-> (levelOut == sampleIn));

  p_down_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd3 && sysClkOk) |=>
      (levelOut == $past(levelOut) || levelOut == $past(levelOut) - 1'b1));

  p_down_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd3) |-> (levelOut <= MID));

  p_sys_loss_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut != 2'd0 && !sysClkOk) |=> (stateOut == 2'd0 && levelOut == '0));

  p_clamp_r9: assert property (@(posedge clk) disable iff (!rstN)
    clampOut == (stateOut == 2'd0));

endmodule

bind softRampCtl softRampChk #(.LVL_W(LVL_W)) i_softRampChk (
  .clk        (clk),
  .rstN       (rstN),
  .sysClkOk   (sysClkOk),
  .frameClkOk (frameClkOk),
  .sampleIn   (sampleIn),
  .levelOut   (levelOut),
  .clampOut   (clampOut),
  .stateOut   (stateOut)
);

// File: tb/test_softRampCtl.sv
module test_softRampCtl;

  localparam int CLK_PERIOD  = 10;
  localparam int LVL_W       = 10;
  localparam int STEP_CYCLES = 4;
  localparam int MID         = 512;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sysClkOk = 1'b0;
  logic             frameClkOk = 1'b0;
  logic [LVL_W-1:0] sampleIn = '0;
  logic [LVL_W-1:0] levelOut;
  logic             clampOut;
  logic [1:0]       stateOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softRampCtl #(.LVL_W(LVL_W), .STEP_CYCLES(STEP_CYCLES)) i_softRampCtl (
    .clk(clk), .rstN(rstN), .sysClkOk(sysClkOk), .frameClkOk(frameClkOk),
    .sampleIn(sampleIn), .levelOut(levelOut), .clampOut(clampOut), .stateOut(stateOut)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; sysClkOk = 1'b0; frameClkOk = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    doReset();
    check("R1 state", stateOut, 0);
    check("R1 level", levelOut, 0);
    check("R1/R9 clamp", clampOut, 1);
  endtask

  task automatic t_partialClocks();
    sysClkOk = 1'b1; sampleIn = 10'h155;
    tick(20);
    check("R2 state sys only", stateOut, 0);
    check("R2/R6 level sys only", levelOut, 0);
    sysClkOk = 1'b0; frameClkOk = 1'b1;
    tick(20);
    check("R2 state frame only", stateOut, 0);
    frameClkOk = 1'b0;
  endtask

  // Full ramp from power-down to normal; returns in normal
  task automatic t_rampUp();
    sysClkOk = 1'b1; frameClkOk = 1'b1; sampleIn = 10'h3FF;
    tick(1);
    check("R3 state", stateOut, 1);
    check("R3 level", levelOut, 0);
    check("R9 clamp off", clampOut, 0);
    tick(STEP_CYCLES - 1);
    check("R4 no early step", levelOut, 0);
    check("R6 sample ignored", levelOut, 0);
    tick(1);
    check("R4 first step", levelOut, 1);
    tick(STEP_CYCLES * 255);
    check("R4 mid ramp", levelOut, 256);
    tick(STEP_CYCLES * 256);
    check("R4 top level", levelOut, MID);
    check("R5 still ramping", stateOut, 1);
    tick(1);
    check("R5 normal", stateOut, 2);
    sampleIn = 10'h2A5;
    #1;
    check("R5 pass a", levelOut, 10'h2A5);
    sampleIn = 10'h05A;
    #1;
    check("R5 pass b", levelOut, 10'h05A);
  endtask

  task automatic t_rampDownAndReturn();
    frameClkOk = 1'b0; sampleIn = 10'h111;
    tick(1);
    check("R7 ramp-down", stateOut, 3);
    check("R7/R6 level held", levelOut, MID);
    tick(STEP_CYCLES * 100);
    check("R7 falling", levelOut, MID - 100);
    frameClkOk = 1'b1;
    tick(STEP_CYCLES * (MID - 100));
    check("R10 reached zero", levelOut, 0);
    check("R10 still ramp-down", stateOut, 3);
    tick(1);
    check("R7 power-down", stateOut, 0);
    check("R9 clamp back", clampOut, 1);
    tick(1);
    check("R10 rearmed", stateOut, 1);
  endtask

  task automatic t_sysLossInRamp();
    doReset();
    sysClkOk = 1'b1; frameClkOk = 1'b1;
    tick(1 + STEP_CYCLES * 50);
    check("R4 partial ramp", levelOut, 50);
    sysClkOk = 1'b0;
    tick(1);
    check("R8 state", stateOut, 0);
    check("R8 level", levelOut, 0);
    check("R8 clamp", clampOut, 1);
  endtask

  task automatic t_sysLossInNormal();
    doReset();
    t_rampUp();
    sysClkOk = 1'b0;
    tick(1);
    check("R8 from normal state", stateOut, 0);
    check("R8 from normal level", levelOut, 0);
  endtask

  initial begin
    t_reset();
    t_partialClocks();
    t_rampUp();
    t_rampDownAndReturn();
    t_sysLossInRamp();
    t_sysLossInNormal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule